// File: doc/BRIEF.md
# Low-Power Sleep Wake-Up Timer

A 32-bit up-counter keeps system time and raises an interrupt or a wake-up request at programmed counts. The counter advances on ticks of one of two slow clocks: a calibrated 1 kHz reference or a 32.768 kHz crystal. A control bit selects which one. Each slow clock reaches the block as a one-cycle tick enable in the fast system clock domain. A power-of-two prescaler sits between the selected tick and the counter, so the timer can span very long sleep periods.

Two compare channels and a rollover detector each set a sticky flag. Each flag goes to the interrupt line through an interrupt mask and to the wake line through a separate wake mask. A debug-halt input freezes the prescaler and the counter while it is high, and no software bit is needed for this. If the selected slow clock stops, no ticks arrive, so the timer neither counts nor wakes.

Software reaches the block through a small word-addressed register port. Reads are registered and return one cycle after the request.

Top module: `slow_wake_timer`

## Requirements
- R1: After reset the following hold:
  - the counter, both compare registers, the flags and both masks read 0;
  - the control register reads 0, which selects the 1 kHz reference with prescaler exponent 0;
  - `irqOut` and `wakeOut` are low.
- R2: Control register bit 0 (address 0) picks the tick source: 0 for `refTick`, 1 for `xtalTick`. Pulses on the unselected input have no effect on the counter.
- R3: Control register bits 7:4 hold the exponent N (0 to 15). The counter advances by exactly 1 once per 2^N ticks of the selected source, and at no other time.
- R4: A control write that changes N restarts the prescaler from zero. A write that keeps N leaves the prescaler count alone.
- R5: While `dbgHalt` is high, neither the prescaler nor the counter moves, and source ticks are lost. On release, counting resumes from the held state.
- R6: Writing address 1 loads the counter at that clock edge. The new value reads back on the next access. A load takes priority over a tick in the same cycle.
- R7: The compare registers sit at address 2 (channel A) and address 3 (channel B). A channel's flag sets on the tick that makes the counter equal to that channel's compare value. Flag register (address 4) bit 0 is channel A and bit 1 is channel B.
- R8: Flag bit 2 sets on the tick that rolls the counter from 0xFFFFFFFF to 0.
- R9: Flags are sticky and clear only when 1 is written to their bit at address 4. Writing 0 leaves a flag unchanged. If a flag sets and is cleared in the same cycle, the set wins.
- R10: The interrupt mask is at address 5 and the wake mask at address 6, bits 2:0, aligned with the flag bits. `irqOut` is high when any flag is set in the same bit as the interrupt mask. `wakeOut` is high when any flag is set in the same bit as the wake mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle tick from the 1 kHz reference |
| xtalTick | input | 1 | One-cycle tick from the 32.768 kHz crystal |
| dbgHalt | input | 1 | Debug halt; freezes counting while high |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read request |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with `rdValid` |
| rdValid | output | 1 | High one cycle after a read request |
| irqOut | output | 1 | Masked OR of the flags, interrupt path |
| wakeOut | output | 1 | Masked OR of the flags, wake path |

## Verification
The bench targets several corner cases, each with a visible failure mode:
- Prescaler ratios. An off-by-one divider would show up as one count too many or too few after an exact number of source ticks.
- Exponent change. A prescaler that kept its count across the change would skip the next expected step.
- Debug halt. A halted prescaler that still absorbed ticks would step early after release.
- Compare and rollover. A flag set from the old counter value instead of the new one would appear one tick late. A missed rollover would leave bit 2 clear.
- Flag clearing. The bench clears a flag in the same cycle as a new hit; a clear that overrides the set would lose that event.
- Masking. A mask applied to the wrong path would raise `irqOut` or `wakeOut` from the other mask.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCount;   // load counter from write data
    logic presClear;   // restart prescaler
    logic srcTick;     // selected source tick, already gated by halt
  } wk_strobe_t;
endpackage

// File: rtl/wk_prescaler.sv
module wk_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srcTick,
  input  logic             clear,
  input  logic [EXP_W-1:0] expo,
  output logic             stepOut
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   limitWide;
  logic [PRE_W-1:0] limit;

  // Terminal count is 2^expo - 1.
  assign limitWide = ({{PRE_W{1'b0}}, 1'b1} << expo) - {{PRE_W{1'b0}}, 1'b1};
  assign limit     = limitWide[PRE_W-1:0];
  assign stepOut   = srcTick && (preCnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       preCnt <= '0;
    else if (clear)   preCnt <= '0;
    else if (srcTick) preCnt <= stepOut ? '0 : preCnt + 1'b1;
  end
endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int EXP_W   = 4,
  parameter int NUM_CMP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wk_strobe_t         strb,
  input  logic [CNT_W-1:0]   loadValue,
  input  logic [EXP_W-1:0]   expo,
  input  logic [CNT_W-1:0]   cmpVals [NUM_CMP],
  output logic [CNT_W-1:0]   countVal,
  output logic [NUM_CMP-1:0] hitVec,
  output logic               wrapEvt,
  output logic               stepEvt
);
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;
  logic             stepRaw;
  logic             advance;

  wk_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .srcTick (strb.srcTick),
    .clear   (strb.presClear),
    .expo    (expo),
    .stepOut (stepRaw)
  );

  assign advance   = stepRaw && !strb.loadCount;
  assign countNext = countQ + 1'b1;
  assign stepEvt   = stepRaw;
  assign wrapEvt   = advance && (countQ == {CNT_W{1'b1}});

  // One comparator per channel, checked against the value about to be stored.
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign hitVec[g] = advance && (countNext == cmpVals[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              countQ <= '0;
    else if (strb.loadCount) countQ <= loadValue;
    else if (advance)        countQ <= countNext;
  end

  assign countVal = countQ;
endmodule

// File: rtl/wk_control.sv
module wk_control
  import wk_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int EXP_W   = 4,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CNT_W-1:0]   regWdata,
  input  logic               refTick,
  input  logic               xtalTick,
  input  logic               dbgHalt,
  input  logic [CNT_W-1:0]   countVal,
  input  logic [NUM_CMP-1:0] hitVec,
  input  logic               wrapEvt,
  output wk_strobe_t         strb,
  output logic [CNT_W-1:0]   loadValue,
  output logic [EXP_W-1:0]   expo,
  output logic [CNT_W-1:0]   cmpVals [NUM_CMP],
  output logic [CNT_W-1:0]   regRdata,
  output logic               rdValid,
  output logic [NUM_CMP:0]   flagsOut,
  output logic               irqOut,
  output logic               wakeOut
);
  localparam int FLAG_N = NUM_CMP + 1;
  localparam int EXP_LSB = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(2 + NUM_CMP);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(3 + NUM_CMP);
  localparam logic [ADDR_W-1:0] A_WMASK = ADDR_W'(4 + NUM_CMP);

  logic              srcSelQ;
  logic [EXP_W-1:0]  expoQ;
  logic [FLAG_N-1:0] flagsQ, irqMaskQ, wakeMaskQ;
  logic [FLAG_N-1:0] setMask, clrMask;
  logic [CNT_W-1:0]  rdNext, rdataQ;
  logic              rdValidQ;
  logic              wrCtrl;

  assign wrCtrl = regWe && (regAddr == A_CTRL);

  always_comb begin
    strb.loadCount = regWe && (regAddr == A_COUNT);
    strb.presClear = wrCtrl && (regWdata[EXP_LSB +: EXP_W] != expoQ);
    strb.srcTick   = !dbgHalt && (srcSelQ ? xtalTick : refTick);
  end
  assign loadValue = regWdata;
  assign expo      = expoQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcSelQ <= 1'b0;
      expoQ   <= '0;
    end else if (wrCtrl) begin
      srcSelQ <= regWdata[0];
      expoQ   <= regWdata[EXP_LSB +: EXP_W];
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmpReg
    always_ff @(posedge clk) begin
      if (!rst_n) cmpVals[g] <= '0;
      else if (regWe && (regAddr == ADDR_W'(2 + g))) cmpVals[g] <= regWdata;
    end
  end

  // Hardware set wins over a software clear in the same cycle.
  assign setMask = {wrapEvt, hitVec};
  assign clrMask = (regWe && (regAddr == A_FLAGS)) ? regWdata[FLAG_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagsQ    <= '0;
      irqMaskQ  <= '0;
      wakeMaskQ <= '0;
    end else begin
      flagsQ <= (flagsQ & ~clrMask) | setMask;
      if (regWe && (regAddr == A_IMASK)) irqMaskQ  <= regWdata[FLAG_N-1:0];
      if (regWe && (regAddr == A_WMASK)) wakeMaskQ <= regWdata[FLAG_N-1:0];
    end
  end

  assign flagsOut = flagsQ;
  assign irqOut   = |(flagsQ & irqMaskQ);
  assign wakeOut  = |(flagsQ & wakeMaskQ);

  always_comb begin
    rdNext = '0;
    if (regAddr == A_CTRL) begin
      rdNext[0] = srcSelQ;
      rdNext[EXP_LSB +: EXP_W] = expoQ;
    end
    if (regAddr == A_COUNT) rdNext = countVal;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (regAddr == ADDR_W'(2 + k)) rdNext = cmpVals[k];
    end
    if (regAddr == A_FLAGS) rdNext[FLAG_N-1:0] = flagsQ;
    if (regAddr == A_IMASK) rdNext[FLAG_N-1:0] = irqMaskQ;
    if (regAddr == A_WMASK) rdNext[FLAG_N-1:0] = wakeMaskQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdataQ   <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= regRe;
      if (regRe) rdataQ <= rdNext;
    end
  end

  assign regRdata = rdataQ;
  assign rdValid  = rdValidQ;
endmodule

// File: rtl/slow_wake_timer.sv
module slow_wake_timer
  import wk_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int EXP_W   = 4,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refTick,
  input  logic              xtalTick,
  input  logic              dbgHalt,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              rdValid,
  output logic              irqOut,
  output logic              wakeOut
);
  wk_strobe_t         strb;
  logic [CNT_W-1:0]   loadValue;
  logic [EXP_W-1:0]   expo;
  logic [CNT_W-1:0]   cmpVals [NUM_CMP];
  logic [CNT_W-1:0]   countNow;
  logic [NUM_CMP-1:0] hitVec;
  logic               wrapEvt;
  logic               stepEvt;
  logic [NUM_CMP:0]   flagsNow;

  wk_control #(.CNT_W(CNT_W), .EXP_W(EXP_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .refTick(refTick), .xtalTick(xtalTick), .dbgHalt(dbgHalt),
    .countVal(countNow), .hitVec(hitVec), .wrapEvt(wrapEvt), .strb(strb),
    .loadValue(loadValue), .expo(expo), .cmpVals(cmpVals), .regRdata(regRdata),
    .rdValid(rdValid), .flagsOut(flagsNow), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  wk_datapath #(.CNT_W(CNT_W), .EXP_W(EXP_W), .NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadValue(loadValue), .expo(expo),
    .cmpVals(cmpVals), .countVal(countNow), .hitVec(hitVec), .wrapEvt(wrapEvt),
    .stepEvt(stepEvt)
  );
endmodule

// File: rtl/wk_checker.sv
module wk_checker #(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int NUM_CMP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbgHalt,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWdata,
  input logic [CNT_W-1:0]  countNow,
  input logic              stepEvt,
  input logic [NUM_CMP:0]  flagsNow,
  input logic              irqOut,
  input logic              wakeOut
);
  logic cntWr, flagWr;
  assign cntWr  = regWe && (regAddr == ADDR_W'(1));
  assign flagWr = regWe && (regAddr == ADDR_W'(2 + NUM_CMP));

  p_halt_nostep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbgHalt |-> !stepEvt);
  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgHalt && !cntWr) |=> $stable(countNow));
  p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepEvt && !cntWr) |=> (countNow == $past(countNow) + 1'b1));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stepEvt && !cntWr) |=> $stable(countNow));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cntWr |=> (countNow == $past(regWdata)));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stepEvt && !cntWr && (countNow == {CNT_W{1'b1}})) |=> flagsNow[NUM_CMP]);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flagsNow[0] && !(flagWr && regWdata[0])) |=> flagsNow[0]);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flagsNow == '0) |-> (!irqOut && !wakeOut));
endmodule

bind slow_wake_timer wk_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbgHalt(dbgHalt), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .countNow(countNow), .stepEvt(stepEvt), .flagsNow(flagsNow),
  .irqOut(irqOut), .wakeOut(wakeOut)
);

// File: tb/sim_slow_wake_timer.sv
`timescale 1ns/1ps
module sim_slow_wake_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refTick = 1'b0, xtalTick = 1'b0, dbgHalt = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rdValid, irqOut, wakeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  slow_wake_timer u0 (
    .clk(clk), .rst_n(rst_n), .refTick(refTick), .xtalTick(xtalTick), .dbgHalt(dbgHalt),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rdValid(rdValid), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // Monitor: pops an expected read value for every returned read.
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      logic [31:0] e;
      string t;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", regRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk); regRe = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic pulse(input bit xtal, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (xtal) xtalTick = 1'b1; else refTick = 1'b1;
      @(negedge clk);
      xtalTick = 1'b0; refTick = 1'b0;
    end
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    pin(irqOut, 1'b0, "R1 irqOut");
    pin(wakeOut, 1'b0, "R1 wakeOut");
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 count");
    rd(3'd2, 32'h0, "R1 cmpA");
    rd(3'd4, 32'h0, "R1 flags");
    rd(3'd5, 32'h0, "R1 irq mask");
    // R2 source select
    pulse(0, 5);
    rd(3'd1, 32'd5, "R2 ref ticks counted");
    pulse(1, 3);
    rd(3'd1, 32'd5, "R2 xtal ignored");
    wr(3'd0, 32'h1);
    pulse(1, 2);
    rd(3'd1, 32'd7, "R2 xtal counted");
    pulse(0, 2);
    rd(3'd1, 32'd7, "R2 ref ignored");
    // R3 prescaler ratios
    wr(3'd0, 32'h21);
    wr(3'd1, 32'h0);
    pulse(1, 7);
    rd(3'd1, 32'd1, "R3 N=2 after 7");
    pulse(1, 1);
    rd(3'd1, 32'd2, "R3 N=2 after 8");
    wr(3'd0, 32'h31);
    wr(3'd1, 32'h0);
    pulse(1, 7);
    rd(3'd1, 32'd0, "R3 N=3 after 7");
    pulse(1, 1);
    rd(3'd1, 32'd1, "R3 N=3 after 8");
    rd(3'd0, 32'h31, "R3 ctrl readback");
    // R4 exponent change restarts prescaler
    wr(3'd0, 32'h21);
    wr(3'd1, 32'h0);
    pulse(1, 3);
    wr(3'd0, 32'h11);
    pulse(1, 1);
    rd(3'd1, 32'd0, "R4 one tick after change");
    pulse(1, 1);
    rd(3'd1, 32'd1, "R4 two ticks after change");
    // R5 debug halt
    pulse(1, 1);
    @(negedge clk); dbgHalt = 1'b1;
    pulse(1, 3);
    rd(3'd1, 32'd1, "R5 frozen while halted");
    @(negedge clk); dbgHalt = 1'b0;
    pulse(1, 1);
    rd(3'd1, 32'd2, "R5 resumes from held prescaler");
    // R6 counter load
    wr(3'd1, 32'h12345678);
    rd(3'd1, 32'h12345678, "R6 load readback");
    // R7 compare channels
    wr(3'd0, 32'h1);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd102);
    rd(3'd3, 32'd102, "R7 cmpB readback");
    wr(3'd1, 32'd98);
    pulse(1, 1);
    rd(3'd4, 32'h0, "R7 no hit at 99");
    pulse(1, 1);
    rd(3'd4, 32'h1, "R7 channel A at 100");
    pulse(1, 2);
    rd(3'd4, 32'h3, "R7 channel B at 102");
    // R10 masks
    pin(irqOut, 1'b0, "R10 irq masked");
    wr(3'd5, 32'h2);
    pin(irqOut, 1'b1, "R10 irq via B");
    pin(wakeOut, 1'b0, "R10 wake masked");
    wr(3'd6, 32'h1);
    pin(wakeOut, 1'b1, "R10 wake via A");
    // R9 write-one-to-clear
    wr(3'd4, 32'h0);
    rd(3'd4, 32'h3, "R9 write 0 keeps flags");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'h2, "R9 clear A only");
    pin(wakeOut, 1'b0, "R10 wake drops with A");
    pin(irqOut, 1'b1, "R10 irq stays with B");
    wr(3'd4, 32'h2);
    pin(irqOut, 1'b0, "R9 irq drops after clear");
    // R9 set wins over clear
    wr(3'd1, 32'd99);
    pulse(1, 1);
    wr(3'd1, 32'd99);
    @(negedge clk);
    xtalTick = 1'b1; regWe = 1'b1; regAddr = 3'd4; regWdata = 32'h1;
    @(negedge clk);
    xtalTick = 1'b0; regWe = 1'b0;
    rd(3'd4, 32'h1, "R9 set wins");
    wr(3'd4, 32'h7);
    // R8 rollover
    wr(3'd1, 32'hFFFF_FFFE);
    pulse(1, 1);
    rd(3'd4, 32'h0, "R8 no wrap at max");
    pulse(1, 1);
    rd(3'd4, 32'h4, "R8 wrap flag");
    rd(3'd1, 32'h0, "R8 counter at zero");
    wr(3'd5, 32'h4);
    pin(irqOut, 1'b1, "R10 irq via wrap");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule